// File: doc/BRIEF.md
# Data Bus Turnaround Spacing Enforcer

This block sits beside the column-command arbiter of a multi-rank DRAM controller and decides, cycle by cycle, whether the candidate column command may go out without violating the data-bus turnaround spacing. It remembers only the most recent issued command: whether it was a read or a write, and which rank it targeted. From that command and the candidate's own type and rank it selects one of six transition classes and holds the candidate back until enough idle controller cycles have passed.

The six classes are: read then write on one rank, write then read on one rank, and read-read, read-write, write-write and write-read across two different ranks. Each class has a base gap and an extra gap, both supplied as register-style inputs. Its spacing is their sum, counted in controller clock cycles. A read followed by a read, or a write followed by a write, on the same rank needs no turnaround spacing from this block.

A small state machine holds the history. `ST_NONE` means no command has been seen since reset. `ST_LAST_RD` and `ST_LAST_WR` mean the last issued command was a read or a write. Every `cmd_issue` moves the machine to `ST_LAST_RD` or `ST_LAST_WR` according to `cand_is_wr`, from any state. Only reset returns it to `ST_NONE`. One down-counter for each class is loaded on every issue.

Top module: `tas_spacing_enforcer`

## Requirements
- R1: While reset is held, and after reset until the first `cmd_issue`, `permit` is 1 for every candidate type and rank.
- R2: After a read to rank k is issued, a write candidate to rank k has `permit` 0 until G0 clock edges have passed since the issuing edge, then 1. G0 = base field 0 + extra field 0, and field i occupies bits [i*GAP_W +: GAP_W] of `base_gap` and `extra_gap`.
- R3: After a write to rank k is issued, a read candidate to rank k is spaced by G1, from field 1, under the same rule as R2.
- R4: Across two different ranks, the spacing after the last issued command uses a field chosen by the transition. Read to read uses field 2, read to write uses field 3, write to write uses field 4 and write to read uses field 5.
- R5: A candidate of the same type and rank as the last issued command always has `permit` 1.
- R6: A spacing of 0 gives `permit` 1 in the first cycle after the issue. A spacing of G blocks the candidate for exactly G cycles. Base and extra add without wrapping.
- R7: Only the most recent `cmd_issue` counts. A new issue replaces the spacing set up by every earlier command, and the class is taken from the new command's type and rank.
- R8: The gap inputs are sampled at the issuing edge. Changing them while a spacing window runs does not alter that window.
- R9: `permit` follows a change of `cand_is_wr` or `cand_rank` in the same cycle, with no register on that path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_is_wr | input | 1 | Candidate command type: 1 for a write, 0 for a read |
| cand_rank | input | RANK_W | Rank targeted by the candidate |
| cmd_issue | input | 1 | The candidate is issued at this clock edge |
| base_gap | input | 6*GAP_W | Base spacing for each class; field i at [i*GAP_W +: GAP_W] |
| extra_gap | input | 6*GAP_W | Extra spacing for each class, same layout as `base_gap` |
| permit | output | 1 | The candidate may be issued in this cycle |

## Verification
`permit` is a combinational function of the candidate inputs and the registered history, so its response to a candidate change is due in the same cycle. The effect of a `cmd_issue` appears only after the clock edge that samples it. A spacing of G keeps `permit` low through the G cycles that follow that edge, and `permit` rises in cycle G+1. The bench drives all inputs just after the falling edge and compares `permit` a little later, in the same low phase, against a behavioural model. The model updates its issue history at each rising edge and measures elapsed time with a plain edge counter.

// File: rtl/tas_pkg.sv
package tas_pkg;

    localparam int unsigned N_CLS = 6;

    // transition classes, index = field position in the gap buses
    localparam int unsigned CLS_RW_SAME = 0;
    localparam int unsigned CLS_WR_SAME = 1;
    localparam int unsigned CLS_RR_XR   = 2;
    localparam int unsigned CLS_RW_XR   = 3;
    localparam int unsigned CLS_WW_XR   = 4;
    localparam int unsigned CLS_WR_XR   = 5;

    typedef enum logic [1:0] {
        ST_NONE    = 2'd0,
        ST_LAST_RD = 2'd1,
        ST_LAST_WR = 2'd2
    } tas_state_e;

    // a class whose first command is a write
    function automatic logic cls_from_write(input int unsigned cls);
        return (cls == CLS_WR_SAME) || (cls == CLS_WW_XR) || (cls == CLS_WR_XR);
    endfunction

endpackage

// File: rtl/tas_class_decode.sv
module tas_class_decode
    import tas_pkg::*;
#(
    parameter int unsigned RANK_W = 2
) (
    input  logic              last_is_wr,
    input  logic [RANK_W-1:0] last_rank,
    input  logic              cand_is_wr,
    input  logic [RANK_W-1:0] cand_rank,
    output logic [N_CLS-1:0]  cls_sel,
    output logic              exempt
);

    logic same_rank;

    always_comb begin
        same_rank = (last_rank == cand_rank);
        cls_sel   = '0;
        exempt    = 1'b0;
        unique case ({last_is_wr, cand_is_wr})
            2'b00: if (same_rank) exempt = 1'b1; else cls_sel[CLS_RR_XR] = 1'b1;
            2'b01: if (same_rank) cls_sel[CLS_RW_SAME] = 1'b1; else cls_sel[CLS_RW_XR] = 1'b1;
            2'b10: if (same_rank) cls_sel[CLS_WR_SAME] = 1'b1; else cls_sel[CLS_WR_XR] = 1'b1;
            2'b11: if (same_rank) exempt = 1'b1; else cls_sel[CLS_WW_XR] = 1'b1;
            default: exempt = 1'b1;
        endcase
    end

endmodule

// File: rtl/tas_gap_adder.sv
module tas_gap_adder
    import tas_pkg::*;
#(
    parameter int unsigned GAP_W = 4,
    localparam int unsigned CNT_W = GAP_W + 1
) (
    input  logic [N_CLS*GAP_W-1:0] base_gap,
    input  logic [N_CLS*GAP_W-1:0] extra_gap,
    output logic [N_CLS*CNT_W-1:0] gap_sum
);

    for (genvar i = 0; i < N_CLS; i++) begin : g_sum
        assign gap_sum[i*CNT_W +: CNT_W] =
            {1'b0, base_gap[i*GAP_W +: GAP_W]} + {1'b0, extra_gap[i*GAP_W +: GAP_W]};
    end

endmodule

// File: rtl/tas_gap_counter.sv
module tas_gap_counter #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R6: one cycle of spacing is used up per clock while no issue arrives
    p_one_per_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8: the window holds the value captured at the issuing edge
    p_captured_at_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/tas_spacing_enforcer.sv
module tas_spacing_enforcer
    import tas_pkg::*;
#(
    parameter int unsigned NUM_RANKS = 4,
    parameter int unsigned GAP_W     = 4,
    localparam int unsigned RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
    localparam int unsigned CNT_W    = GAP_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cand_is_wr,
    input  logic [RANK_W-1:0]       cand_rank,
    input  logic                    cmd_issue,
    input  logic [N_CLS*GAP_W-1:0]  base_gap,
    input  logic [N_CLS*GAP_W-1:0]  extra_gap,
    output logic                    permit
);

    tas_state_e        state_q, state_d;
    logic [RANK_W-1:0] last_rank_q;
    logic [N_CLS*CNT_W-1:0] gap_sum;
    logic [N_CLS-1:0]  cls_sel;
    logic [N_CLS-1:0]  expired;
    logic              exempt;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_NONE;
            last_rank_q <= '0;
        end else begin
            state_q <= state_d;
            if (cmd_issue) last_rank_q <= cand_rank;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NONE, ST_LAST_RD, ST_LAST_WR: begin
                if (cmd_issue) state_d = cand_is_wr ? ST_LAST_WR : ST_LAST_RD;
            end
            default: state_d = ST_NONE;
        endcase
    end

    // ---------------- gap sums and class select ----------------
    tas_gap_adder #(.GAP_W(GAP_W)) u_adder (
        .base_gap  (base_gap),
        .extra_gap (extra_gap),
        .gap_sum   (gap_sum)
    );

    tas_class_decode #(.RANK_W(RANK_W)) u_decode (
        .last_is_wr (state_q == ST_LAST_WR),
        .last_rank  (last_rank_q),
        .cand_is_wr (cand_is_wr),
        .cand_rank  (cand_rank),
        .cls_sel    (cls_sel),
        .exempt     (exempt)
    );

    // ---------------- one window per class ----------------
    for (genvar i = 0; i < N_CLS; i++) begin : g_win
        logic [CNT_W-1:0] win_val;
        // classes that start from the other command type are cleared
        assign win_val = (cls_from_write(i) == cand_is_wr) ? gap_sum[i*CNT_W +: CNT_W] : '0;

        tas_gap_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cmd_issue),
            .load_val (win_val),
            .expired  (expired[i])
        );
    end

    // ---------------- outputs ----------------
    always_comb begin
        unique case (state_q)
            ST_NONE:    permit = 1'b1;
            ST_LAST_RD,
            ST_LAST_WR: permit = exempt | (|(cls_sel & expired));
            default:    permit = 1'b1;
        endcase
    end

    // ---------------- assertions ----------------
    p_no_history_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NONE) |-> permit);

    p_rd_to_wr_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && !cand_is_wr && gap_sum[CLS_RW_SAME*CNT_W +: CNT_W] != '0)
        |=> (!(cand_is_wr && cand_rank == $past(cand_rank)) || !permit));

    p_wr_to_rd_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && cand_is_wr && gap_sum[CLS_WR_SAME*CNT_W +: CNT_W] != '0)
        |=> (!(!cand_is_wr && cand_rank == $past(cand_rank)) || !permit));

    p_single_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cls_sel) && !(exempt && cls_sel != '0));

    p_same_kind_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_NONE && cand_is_wr == (state_q == ST_LAST_WR)
         && cand_rank == last_rank_q) |-> permit);

endmodule

// File: tb/tas_spacing_enforcer_tb_top.sv
module tas_spacing_enforcer_tb_top;

    localparam int NR    = 4;
    localparam int GW    = 4;
    localparam int RW    = 2;
    localparam int NC    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cand_is_wr = 1'b0;
    logic [RW-1:0]     cand_rank = '0;
    logic              cmd_issue = 1'b0;
    logic [NC*GW-1:0]  base_gap = '0;
    logic [NC*GW-1:0]  extra_gap = '0;
    logic              permit;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // reference model state
    bit  m_have = 0;
    bit  m_wr   = 0;
    int  m_rank = 0;
    int  m_cyc  = 0;
    int  m_last = 0;
    int  m_gap [NC];

    always #10 clk = ~clk;   // 50 MHz

    tas_spacing_enforcer #(.NUM_RANKS(NR), .GAP_W(GW)) dut_i (
        .clk, .rst_n, .cand_is_wr, .cand_rank, .cmd_issue,
        .base_gap, .extra_gap, .permit
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_have = 0;
        end else begin
            m_cyc++;
            if (cmd_issue) begin
                m_have = 1;
                m_wr   = cand_is_wr;
                m_rank = int'(cand_rank);
                m_last = m_cyc;
                for (int i = 0; i < NC; i++)
                    m_gap[i] = int'(base_gap[i*GW +: GW]) + int'(extra_gap[i*GW +: GW]);
            end
        end
    end

    // class index from the requirement table, -1 when exempt or no history
    function automatic int model_class(bit cw, int cr);
        bit same;
        if (!m_have) return -1;
        same = (cr == m_rank);
        if (!m_wr && !cw) return same ? -1 : 2;
        if (!m_wr &&  cw) return same ?  0 : 3;
        if ( m_wr && !cw) return same ?  1 : 5;
        return same ? -1 : 4;
    endfunction

    function automatic string class_req(bit cw, int cr);
        int c;
        c = model_class(cw, cr);
        if (!m_have) return "R1";
        if (c < 0)   return "R5";
        if (c == 0)  return "R2";
        if (c == 1)  return "R3";
        return "R4";
    endfunction

    function automatic bit model_permit(bit cw, int cr);
        int c;
        c = model_class(cw, cr);
        if (c < 0) return 1'b1;
        return (m_cyc - m_last) >= m_gap[c];
    endfunction

    task automatic compare(string note);
        bit exp;
        exp = model_permit(cand_is_wr, int'(cand_rank));
        vectors++;
        if (permit !== exp) begin
            fails++;
            $display("FAIL %s%s: cand wr=%0d rank=%0d permit=%0b expected=%0b at cycle %0d",
                     class_req(cand_is_wr, int'(cand_rank)), note, cand_is_wr, cand_rank,
                     permit, exp, m_cyc);
        end
    endtask

    // drive after the falling edge, compare within the same low phase
    task automatic step(bit cw, int cr, bit iss, string note);
        @(negedge clk);
        cand_is_wr = cw;
        cand_rank  = RW'(cr);
        cmd_issue  = iss;
        #3;
        compare(note);
    endtask

    task automatic set_gap(int cls, int b, int e);
        base_gap[cls*GW +: GW]  = GW'(b);
        extra_gap[cls*GW +: GW] = GW'(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: run did not end, got running expected finished");
        finish_run();
    end

    initial begin
        // R1: permitted during and just after reset
        for (int r = 0; r < NR; r++) begin
            cand_is_wr = r[0]; cand_rank = RW'(r); #3; compare(" reset held");
            #2;
        end
        @(negedge clk); rst_n = 1'b1;
        for (int r = 0; r < NR; r++) step(r[0], r, 0, " no history");

        // R2 / R6: read then write same rank, spacing 2 + 3
        set_gap(0, 2, 3);
        step(0, 1, 1, " issue read");
        for (int k = 0; k < 7; k++) step(1, 1, 0, " rd->wr window");

        // R3 with extra at maximum, base 0
        set_gap(1, 0, 15);
        step(1, 2, 1, " issue write");
        for (int k = 0; k < 17; k++) step(0, 2, 0, " wr->rd window");

        // R4: cross-rank classes each with its own field
        set_gap(2, 1, 0); set_gap(3, 2, 2); set_gap(4, 3, 3); set_gap(5, 4, 4);
        step(0, 0, 1, " issue read r0");
        for (int k = 0; k < 5; k++) begin
            step(0, 3, 0, " rd->rd other rank");
            step(1, 3, 0, " rd->wr other rank");
        end
        step(1, 0, 1, " issue write r0");
        for (int k = 0; k < 10; k++) begin
            step(1, 2, 0, " wr->wr other rank");
            step(0, 2, 0, " wr->rd other rank");
            step(1, 0, 0, " R5 same kind");
        end

        // R6: zero spacing permits at once; saturated sum 30 without wrap
        set_gap(0, 0, 0);
        step(0, 3, 1, " R6 zero gap issue");
        step(1, 3, 0, " R6 zero gap");
        set_gap(0, 15, 15);
        step(0, 3, 1, " R6 max gap issue");
        for (int k = 0; k < 32; k++) step(1, 3, 0, " R6 max gap");

        // R7: second issue replaces the first window
        set_gap(0, 8, 0); set_gap(1, 2, 0);
        step(0, 1, 1, " R7 first read");
        step(1, 1, 1, " R7 write replaces");
        for (int k = 0; k < 4; k++) step(0, 1, 0, " R7 class from new command");

        // R8: gap inputs changed mid-window do not alter it
        set_gap(3, 5, 0);
        step(0, 0, 1, " R8 issue");
        set_gap(3, 0, 0);
        for (int k = 0; k < 7; k++) step(1, 2, 0, " R8 window kept");

        // R9: candidate toggled each cycle while a window runs
        set_gap(0, 6, 0);
        step(0, 2, 1, " R9 issue");
        for (int k = 0; k < 8; k++) step(k[0], 2, 0, " R9 same-cycle response");

        // mixed pattern with changing gaps
        for (int n = 0; n < 4000; n++) begin
            if (n % 97 == 0)
                for (int i = 0; i < NC; i++) set_gap(i, $urandom % 16, $urandom % 8);
            step($urandom % 2, $urandom % NR, ($urandom % 4) == 0, " mixed");
        end

        // R1: reset in the middle of a window clears history
        set_gap(0, 9, 9);
        step(0, 1, 1, " pre-reset issue");
        @(negedge clk); cmd_issue = 1'b0; rst_n = 1'b0;
        cand_is_wr = 1'b1; cand_rank = 2'd1; #3; compare(" R1 reset mid window");
        @(negedge clk); rst_n = 1'b1;
        step(1, 1, 0, " R1 after second reset");

        @(negedge clk); cmd_issue = 1'b0;
        finish_run();
    end

endmodule